// File: doc/BRIEF.md
# Descriptor Pointer Fetch Queue

This block sits at the front of one processing channel and keeps the channel supplied with work. Host software places a descriptor in memory and then writes its address, as one 64-bit word, into a write-only enqueue port. The block widens that address, optionally with a 4-bit extension, into a 36-bit pointer and stores it in a first-in first-out queue of up to 24 entries.

The channel runs one descriptor at a time. When the channel has no current descriptor, or when the current one reports that its processing has finished, the block takes the oldest pointer from the queue and raises a fetch request to the bus side with a valid/ready handshake. Only one fetch is in flight at a time. When the bus side pulses fetch completion, the pointer is committed into the current-descriptor register. That register also supplies the destination address for an optional writeback of the modified header word. Occupancy, empty, full and a sticky overflow flag are reported as status.

Top module: `desc_ptr_queue`

## Requirements
- R1: In the enqueue word, bits [31:0] carry the descriptor address and bits [35:32] carry the extension nibble. Bits [63:36] are reserved and have no effect on the stored pointer.
- R2: The 36-bit pointer is {extension, address} when `ext_en_i` is high during the enqueue write, and {4'h0, address} when it is low.
- R3: The queue holds up to 24 pointers and issues them in write order. `q_count_o` gives the occupancy. `q_empty_o` is high at 0 entries and `q_full_o` is high at 24 entries.
- R4: While no descriptor is current, a non-empty queue is popped and `fetch_req_valid_o` rises one cycle after the pop decision. A `proc_done_i` pulse with entries waiting pops the next one directly. One cycle after an enqueue into an idle, empty block, the request is visible and the count is back at 0.
- R5: `fetch_req_valid_o` stays high with a stable `fetch_req_addr_o` until `fetch_req_ready_i` is seen. After the handshake, no new request is raised until `fetch_done_i` and then `proc_done_i` have been seen.
- R6: `cur_ptr_o` keeps its old value through the request and the wait. It takes the fetched pointer on the clock edge that samples `fetch_done_i`.
- R7: `wb_addr_o` equals `cur_ptr_o` while `hdr_wb_en_i` is high, and is zero while it is low.
- R8: A write while the queue holds 24 entries and no pop happens in that cycle is dropped and sets `q_ovf_o`. `q_ovf_o` stays set until `ovf_clr_i`. If a drop and a clear happen in the same cycle, the flag stays set.
- R9: A write and a pop in the same cycle on a full queue: the pop is applied first and the write is accepted, so the count stays 24 and the flag is not set.
- R10: After reset, the count is 0, the queue is empty and not full, and no request is pending. The current pointer is all zeros and the overflow flag is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enq_wr_i | input | 1 | Enqueue write strobe |
| enq_word_i | input | 64 | Enqueue word (address, extension, reserved) |
| ext_en_i | input | 1 | Address extension enable |
| ovf_clr_i | input | 1 | Clears the sticky overflow flag |
| proc_done_i | input | 1 | Current descriptor processing finished |
| fetch_req_valid_o | output | 1 | Fetch request valid |
| fetch_req_ready_i | input | 1 | Fetch request accepted |
| fetch_req_addr_o | output | 36 | Descriptor address to fetch |
| fetch_done_i | input | 1 | Descriptor fetch completed |
| hdr_wb_en_i | input | 1 | Header writeback enable |
| cur_ptr_o | output | 36 | Current descriptor pointer |
| wb_addr_o | output | 36 | Header writeback destination |
| q_count_o | output | 5 | Queue occupancy |
| q_empty_o | output | 1 | Queue empty |
| q_full_o | output | 1 | Queue full |
| q_ovf_o | output | 1 | Sticky overflow flag |

## Verification
The embedded properties check several rules on every cycle: the occupancy bound, the handling of a dropped write at full, acceptance of a write on a full queue when a pop happens in the same cycle, no pop from an empty queue, a request held stable until ready, no back-to-back requests, and changes to the current pointer only after a completion pulse. Other behaviour needs the bench scenarios. These are end-to-end ordering through a wrap of the circular buffer, the widening and reserved-bit behaviour of the enqueue word, the latency from enqueue to request, the writeback address selection, and the clear-versus-set priority of the overflow flag.

// File: rtl/dpq_pkg.sv
package dpq_pkg;
  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_REQ  = 2'd1,
    FS_WAIT = 2'd2,
    FS_BUSY = 2'd3
  } fetch_state_e;
endpackage

// File: rtl/dpq_enq_decode.sv
module dpq_enq_decode #(
  parameter int WORD_W  = 64,
  parameter int ADDR_W  = 32,
  parameter int EXT_W   = 4,
  parameter int EXT_LSB = 32
) (
  input  logic                    wr_i,
  input  logic [WORD_W-1:0]       word_i,
  input  logic                    ext_en_i,
  output logic                    push_o,
  output logic [ADDR_W+EXT_W-1:0] ptr_o
);
  localparam int PTR_W = ADDR_W + EXT_W;
  localparam logic [WORD_W-1:0] FIELD_MASK =
    (WORD_W'({EXT_W{1'b1}}) << EXT_LSB) | WORD_W'({ADDR_W{1'b1}});

  // Widen a raw address with the optional extension nibble.
  function automatic logic [PTR_W-1:0] form_ptr(
    input logic [EXT_W-1:0]  ext,
    input logic [ADDR_W-1:0] addr,
    input logic              en
  );
    return {(en ? ext : {EXT_W{1'b0}}), addr};
  endfunction

  logic [EXT_W-1:0]  ext_field;
  logic [ADDR_W-1:0] addr_field;
  logic              unused_rsvd;

  assign ext_field   = word_i[EXT_LSB +: EXT_W];
  assign addr_field  = word_i[ADDR_W-1:0];
  assign unused_rsvd = ^(word_i & ~FIELD_MASK);
  assign push_o      = wr_i;
  assign ptr_o       = form_ptr(ext_field, addr_field, ext_en_i);
endmodule

// File: rtl/dpq_fifo.sv
module dpq_fifo #(
  parameter int DEPTH  = 24,
  parameter int DATA_W = 36,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              pop_i,
  input  logic              ovf_clr_i,
  output logic [DATA_W-1:0] head_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              empty_o,
  output logic              full_o,
  output logic              ovf_o
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  function automatic logic [IDX_W-1:0] bump(input logic [IDX_W-1:0] i);
    if (i == IDX_W'(DEPTH - 1)) return '0;
    return i + 1'b1;
  endfunction

  logic [DATA_W-1:0] mem [DEPTH];
  logic [IDX_W-1:0]  wr_idx, rd_idx;
  logic [CNT_W-1:0]  count_q;
  logic              ovf_q;
  logic              accept_w, drop_w, pop_w;

  assign empty_o  = (count_q == '0);
  assign full_o   = (count_q == CNT_W'(DEPTH));
  assign pop_w    = pop_i && !empty_o;
  assign accept_w = push_i && (!full_o || pop_w);
  assign drop_w   = push_i && full_o && !pop_w;
  assign head_o   = mem[rd_idx];
  assign count_o  = count_q;
  assign ovf_o    = ovf_q;

  always_ff @(posedge clk) begin
    if (accept_w) mem[wr_idx] <= data_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_idx  <= '0;
      rd_idx  <= '0;
      count_q <= '0;
      ovf_q   <= 1'b0;
    end else begin
      if (accept_w) wr_idx <= bump(wr_idx);
      if (pop_w)    rd_idx <= bump(rd_idx);
      count_q <= count_q + CNT_W'(accept_w) - CNT_W'(pop_w);
      if (drop_w)         ovf_q <= 1'b1;
      else if (ovf_clr_i) ovf_q <= 1'b0;
    end
  end

  // R3
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CNT_W'(DEPTH));

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && full_o && !pop_i) |=> (count_q == $past(count_q)) && ovf_q);

  // R9
  full_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && pop_i && full_o) |=> full_o);

  // R4
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i |-> !empty_o);
endmodule

// File: rtl/dpq_fetch_ctrl.sv
module dpq_fetch_ctrl
  import dpq_pkg::*;
#(
  parameter int PTR_W = 36
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             q_empty_i,
  input  logic [PTR_W-1:0] q_head_i,
  input  logic             proc_done_i,
  input  logic             req_ready_i,
  input  logic             fetch_done_i,
  output logic             pop_o,
  output logic             req_valid_o,
  output logic [PTR_W-1:0] req_addr_o,
  output logic [PTR_W-1:0] cur_ptr_o
);
  fetch_state_e     state_q, state_d;
  logic [PTR_W-1:0] pend_q, cur_q;
  logic             launch_w, hs_fire_w, commit_w;

  assign launch_w  = !q_empty_i &&
                     ((state_q == FS_IDLE) || (state_q == FS_BUSY && proc_done_i));
  assign hs_fire_w = (state_q == FS_REQ) && req_ready_i;
  assign commit_w  = (state_q == FS_WAIT) && fetch_done_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      FS_IDLE: if (launch_w)    state_d = FS_REQ;
      FS_REQ:  if (hs_fire_w)   state_d = FS_WAIT;
      FS_WAIT: if (commit_w)    state_d = FS_BUSY;
      FS_BUSY: if (proc_done_i) state_d = launch_w ? FS_REQ : FS_IDLE;
      default:                  state_d = FS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= FS_IDLE;
      pend_q  <= '0;
      cur_q   <= '0;
    end else begin
      state_q <= state_d;
      if (launch_w) pend_q <= q_head_i;
      if (commit_w) cur_q  <= pend_q;
    end
  end

  assign pop_o       = launch_w;
  assign req_valid_o = (state_q == FS_REQ);
  assign req_addr_o  = pend_q;
  assign cur_ptr_o   = cur_q;

  // R5
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_o && !req_ready_i) |=> (req_valid_o && $stable(req_addr_o)));

  // R5
  single_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_o && req_ready_i) |=> !req_valid_o);

  // R6
  cur_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur_ptr_o) |-> $past(fetch_done_i));
endmodule

// File: rtl/desc_ptr_queue.sv
module desc_ptr_queue #(
  parameter int DEPTH   = 24,
  parameter int WORD_W  = 64,
  parameter int ADDR_W  = 32,
  parameter int EXT_W   = 4,
  parameter int EXT_LSB = 32,
  localparam int PTR_W  = ADDR_W + EXT_W,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enq_wr_i,
  input  logic [WORD_W-1:0] enq_word_i,
  input  logic              ext_en_i,
  input  logic              ovf_clr_i,
  input  logic              proc_done_i,
  output logic              fetch_req_valid_o,
  input  logic              fetch_req_ready_i,
  output logic [PTR_W-1:0]  fetch_req_addr_o,
  input  logic              fetch_done_i,
  input  logic              hdr_wb_en_i,
  output logic [PTR_W-1:0]  cur_ptr_o,
  output logic [PTR_W-1:0]  wb_addr_o,
  output logic [CNT_W-1:0]  q_count_o,
  output logic              q_empty_o,
  output logic              q_full_o,
  output logic              q_ovf_o
);
  logic             push_w, pop_w;
  logic [PTR_W-1:0] push_ptr_w, head_w;

  dpq_enq_decode #(
    .WORD_W(WORD_W), .ADDR_W(ADDR_W), .EXT_W(EXT_W), .EXT_LSB(EXT_LSB)
  ) u_dec (
    .wr_i(enq_wr_i), .word_i(enq_word_i), .ext_en_i(ext_en_i),
    .push_o(push_w), .ptr_o(push_ptr_w)
  );

  dpq_fifo #(.DEPTH(DEPTH), .DATA_W(PTR_W), .CNT_W(CNT_W)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .push_i(push_w), .data_i(push_ptr_w), .pop_i(pop_w), .ovf_clr_i(ovf_clr_i),
    .head_o(head_w), .count_o(q_count_o), .empty_o(q_empty_o),
    .full_o(q_full_o), .ovf_o(q_ovf_o)
  );

  dpq_fetch_ctrl #(.PTR_W(PTR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .q_empty_i(q_empty_o), .q_head_i(head_w), .proc_done_i(proc_done_i),
    .req_ready_i(fetch_req_ready_i), .fetch_done_i(fetch_done_i),
    .pop_o(pop_w), .req_valid_o(fetch_req_valid_o),
    .req_addr_o(fetch_req_addr_o), .cur_ptr_o(cur_ptr_o)
  );

  assign wb_addr_o = hdr_wb_en_i ? cur_ptr_o : '0;

  // R10
  reset_state_chk: assert property (@(posedge clk)
    !rst_n |=> (q_count_o == '0) && !fetch_req_valid_o && (cur_ptr_o == '0) && !q_ovf_o);
endmodule

// File: tb/tb_desc_ptr_queue.sv
`timescale 1ns/1ps
module tb_desc_ptr_queue;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        enq_wr_i, ext_en_i, ovf_clr_i, proc_done_i;
  logic [63:0] enq_word_i;
  logic        fetch_req_valid_o, fetch_req_ready_i, fetch_done_i, hdr_wb_en_i;
  logic [35:0] fetch_req_addr_o, cur_ptr_o, wb_addr_o;
  logic [4:0]  q_count_o;
  logic        q_empty_o, q_full_o, q_ovf_o;

  int n_checks = 0;
  int n_fails  = 0;
  int done_cnt = 0;
  int consumed = 0;
  logic [35:0] exp_q [$];

  always #2.5 clk = ~clk;

  desc_ptr_queue dut (.*);

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: one write per cycle, expected pointer goes to the scoreboard if accepted
  task automatic enq(input logic [3:0] ext, input logic [31:0] a, input bit en,
                     input bit accept, input logic [27:0] rsvd);
    enq_wr_i   = 1'b1;
    enq_word_i = {rsvd, ext, a};
    ext_en_i   = en;
    if (accept) exp_q.push_back({(en ? ext : 4'h0), a});
    @(negedge clk);
    enq_wr_i   = 1'b0;
  endtask

  task automatic finish_one();
    while (done_cnt <= consumed) @(negedge clk);
    proc_done_i = 1'b1;
    @(negedge clk);
    proc_done_i = 1'b0;
    consumed++;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
  endtask

  // monitor + fetch responder
  initial begin
    logic [35:0] got, want, prev;
    fetch_done_i = 1'b0;
    forever begin
      @(negedge clk);
      if (fetch_req_valid_o && fetch_req_ready_i) begin
        got  = fetch_req_addr_o;
        prev = cur_ptr_o;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R3 unexpected fetch", {28'h0, got}, 64'h0);
        end else begin
          want = exp_q.pop_front();
          chk(got == want, "R3 order/R2 address", {28'h0, got}, {28'h0, want});
        end
        @(negedge clk);
        @(negedge clk);
        chk(cur_ptr_o == prev, "R6 no commit before done", {28'h0, cur_ptr_o}, {28'h0, prev});
        chk(!fetch_req_valid_o, "R5 one outstanding", {63'h0, fetch_req_valid_o}, 64'h0);
        fetch_done_i = 1'b1;
        @(negedge clk);
        fetch_done_i = 1'b0;
        chk(cur_ptr_o == got, "R6 commit on done", {28'h0, cur_ptr_o}, {28'h0, got});
        done_cnt++;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; enq_wr_i = 1'b0; enq_word_i = '0; ext_en_i = 1'b0;
    ovf_clr_i = 1'b0; proc_done_i = 1'b0; fetch_req_ready_i = 1'b1; hdr_wb_en_i = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R10
    chk(q_count_o == 0 && q_empty_o && !q_full_o, "R10 queue status", {59'h0, q_count_o}, 64'h0);
    chk(cur_ptr_o == 0 && !q_ovf_o && !fetch_req_valid_o, "R10 pointer/flags",
        {28'h0, cur_ptr_o}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R2 R4: extended pointer, latency to request
    enq(4'hA, 32'h1234_5678, 1'b1, 1'b1, 28'h0);
    chk(q_count_o == 1, "R3 count after write", {59'h0, q_count_o}, 64'd1);
    @(negedge clk);
    chk(fetch_req_valid_o && q_count_o == 0, "R4 request one cycle after pop",
        {63'h0, fetch_req_valid_o}, 64'd1);
    chk(fetch_req_addr_o == 36'hA_1234_5678, "R2 extension applied",
        {28'h0, fetch_req_addr_o}, 64'hA_1234_5678);
    finish_one();

    // R1 R2: reserved bits set, extension disabled
    enq(4'h5, 32'hDEAD_BEEF, 1'b0, 1'b1, 28'hFFF_FFFF);
    while (done_cnt <= consumed) @(negedge clk);
    // R7
    chk(wb_addr_o == 36'h0, "R7 writeback off", {28'h0, wb_addr_o}, 64'h0);
    hdr_wb_en_i = 1'b1;
    #1;
    chk(wb_addr_o == 36'h0_DEAD_BEEF, "R7 writeback on", {28'h0, wb_addr_o}, 64'hDEAD_BEEF);
    chk(cur_ptr_o == 36'h0_DEAD_BEEF, "R1 reserved ignored", {28'h0, cur_ptr_o}, 64'hDEAD_BEEF);
    hdr_wb_en_i = 1'b0;
    finish_one();

    // R5: ready held low
    fetch_req_ready_i = 1'b0;
    enq(4'h3, 32'h0000_4000, 1'b1, 1'b1, 28'h0);
    @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(fetch_req_valid_o && fetch_req_addr_o == 36'h3_0000_4000, "R5 hold until ready",
          {28'h0, fetch_req_addr_o}, 64'h3_0000_4000);
    end
    @(posedge clk);
    #1 fetch_req_ready_i = 1'b1;
    @(negedge clk);
    finish_one();

    // R3 R8 R9: fill, overflow, swap on full, wrap and drain
    enq(4'h1, 32'h0001_0000, 1'b1, 1'b1, 28'h0);
    while (done_cnt <= consumed) @(negedge clk);
    for (int i = 1; i <= 24; i++) enq(4'h2, 32'h0002_0000 + 32'(i), 1'b1, 1'b1, 28'h0);
    chk(q_count_o == 24 && q_full_o && !q_empty_o, "R3 full at 24", {59'h0, q_count_o}, 64'd24);
    chk(!fetch_req_valid_o, "R5 no request while busy", {63'h0, fetch_req_valid_o}, 64'h0);
    enq(4'h0, 32'h0BAD_0001, 1'b1, 1'b0, 28'h0);
    chk(q_ovf_o && q_count_o == 24, "R8 drop sets flag", {59'h0, q_count_o}, 64'd24);
    ovf_clr_i = 1'b1;
    enq(4'h0, 32'h0BAD_0002, 1'b1, 1'b0, 28'h0);
    ovf_clr_i = 1'b0;
    chk(q_ovf_o == 1'b1, "R8 set wins over clear", {63'h0, q_ovf_o}, 64'd1);
    ovf_clr_i = 1'b1;
    @(negedge clk);
    ovf_clr_i = 1'b0;
    chk(q_ovf_o == 1'b0, "R8 clear", {63'h0, q_ovf_o}, 64'h0);
    proc_done_i = 1'b1;
    enq(4'h7, 32'h0003_0000, 1'b1, 1'b1, 28'h0);
    proc_done_i = 1'b0;
    consumed++;
    chk(q_count_o == 24 && !q_ovf_o, "R9 pop then push on full", {59'h0, q_count_o}, 64'd24);
    repeat (25) finish_one();
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R3 all entries issued", 64'(exp_q.size()), 64'h0);
    chk(q_empty_o && q_count_o == 0 && !fetch_req_valid_o, "R3 empty after drain",
        {59'h0, q_count_o}, 64'h0);

    summary();
    $finish;
  end
endmodule